// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands one bit at a time. A single accumulator, one bit wider than twice the operand width, first holds the multiplier in its low half. As the multiplier is shifted out to the right, the low half fills with the low half of the product. A multiplicand register and an adder that is one bit wider than the operand form the rest of the datapath.

Control is split into two parts. A sequencer looks at the start input and at the accumulator's least significant bit. When that bit is 1 it issues an add followed by a shift, and when it is 0 it issues a shift alone. A separate step counter counts the shifts and raises a completion flag once the shift about to be issued is the last one, which brings the sequencer back to idle. The caller pulses start with both operands present, waits for the one-cycle done pulse, and reads the product in that cycle.

Top module: `shiftadd_mult`

## Requirements
- R1: After synchronous reset, `done` is 0 and `product` is 0.
- R2: When `start` is 1 while idle, the next clock loads the multiplier into the low `N` accumulator bits, clears the upper `N+1` bits and captures the multiplicand. In the following cycle `product` reads as the multiplier zero-extended to `2N` bits.
- R3: When the current multiplier bit (accumulator bit 0) is 1, an add step writes the `N+1`-bit sum of accumulator bits `2N-1:N` and the multiplicand into bits `2N:N`. The low bits are left unchanged.
- R4: Every multiplier bit ends in one shift that moves all `2N+1` accumulator bits one place right and fills the top with 0. A 1 bit costs two cycles (add, then shift) and a 0 bit costs one cycle.
- R5: The step counter is cleared on load and advances on each shift. The operation ends on the shift issued while the counter holds `N-1`, so `done` rises exactly `N + popcount(multiplier)` clocks after the load edge.
- R6: `done` is high for exactly one cycle, and in that cycle `product` equals multiplier times multiplicand.
- R7: `start` is ignored while an operation is in progress. Neither the result nor the timing of the current operation changes.
- R8: The largest operands (all ones) give the correct product, and accumulator bit `2N` is 0 when done is high.
- R9: A `start` seen in the cycle where `done` is high begins a new operation, so holding `start` high gives back-to-back multiplications.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| mplier | input | N | Multiplier operand |
| mcand | input | N | Multiplicand operand |
| product | output | 2N | Low 2N accumulator bits; the result when done is high |
| done | output | 1 | One-cycle pulse after the final shift |

## Verification
The bench runs every pair of 4-bit operands and checks both the product and the exact cycle of the done pulse. A cycle count that depends on the multiplier's ones catches a sequencer that skips or repeats an add, and a counter that ends one shift early or late. The all-ones case would expose an adder that drops its carry into the top accumulator bit. A start pulse in the middle of an operation would corrupt the product or move the done pulse in a design that restarts while busy. Holding start high would show a lost or doubled operation in a design that mishandles a start in the done cycle.

// File: rtl/shiftadd_mult_pkg.sv
package shiftadd_mult_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_TEST  = 2'd1,
    SQ_SHIFT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/shiftadd_mult_datapath.sv
module shiftadd_mult_datapath #(
  parameter int N = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic            ad,
  input  logic            sh,
  input  logic [N-1:0]    mplier,
  input  logic [N-1:0]    mcand,
  output logic [2*N:0]    acc,
  output logic            mbit
);
  localparam int AW = 2*N + 1;

  logic [N-1:0] mcand_q;
  logic [N:0]   sum;

  assign sum  = {1'b0, acc[2*N-1:N]} + {1'b0, mcand_q};
  assign mbit = acc[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      mcand_q <= '0;
    end else if (ld) begin
      acc     <= {{(N+1){1'b0}}, mplier};
      mcand_q <= mcand;
    end else if (ad) begin
      acc[2*N:N] <= sum;
    end else if (sh) begin
      acc <= {1'b0, acc[AW-1:1]};
    end
  end

  // R2: load places multiplier low and clears the upper bits
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (acc[2*N:N] == '0) && (acc[N-1:0] == $past(mplier)));

  // R3: add leaves the low half untouched
  a_r3_add_low_kept: assert property (@(posedge clk) disable iff (rst)
    ad |=> acc[N-1:0] == $past(acc[N-1:0]));

  // R4: shift moves everything right by one with zero fill
  a_r4_shift: assert property (@(posedge clk) disable iff (rst)
    sh |=> (acc[2*N] == 1'b0) && (acc[2*N-1:0] == $past(acc[2*N:1])));
endmodule

// File: rtl/shiftadd_mult_counter.sv
module shiftadd_mult_counter #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic sh,
  output logic k
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  assign k = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || ld) begin
      cnt <= '0;
    end else if (sh) begin
      if (k) cnt <= '0;
      else   cnt <= cnt + 1'b1;
    end
  end

  // R5: counter only moves on load or shift
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld && !sh) |=> $stable(cnt));

  // R5: the final shift returns the counter to zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (sh && k) |=> cnt == '0);
endmodule

// File: rtl/shiftadd_mult_seq.sv
module shiftadd_mult_seq
  import shiftadd_mult_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mbit,
  input  logic k,
  output logic ld,
  output logic ad,
  output logic sh,
  output logic done
);
  seq_state_t state, state_nx;

  always_comb begin
    ld       = 1'b0;
    ad       = 1'b0;
    sh       = 1'b0;
    state_nx = state;
    unique case (state)
      SQ_IDLE: begin
        if (start) begin
          ld       = 1'b1;
          state_nx = SQ_TEST;
        end
      end
      SQ_TEST: begin
        if (mbit) begin
          ad       = 1'b1;
          state_nx = SQ_SHIFT;
        end else begin
          sh       = 1'b1;
          state_nx = k ? SQ_IDLE : SQ_TEST;
        end
      end
      SQ_SHIFT: begin
        sh       = 1'b1;
        state_nx = k ? SQ_IDLE : SQ_TEST;
      end
      default: state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= sh && k;
    end
  end

  a_r4_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld, ad, sh}));

  // R4: an add is always followed by a shift
  a_r4_add_then_shift: assert property (@(posedge clk) disable iff (rst)
    ad |=> sh);

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: no load while busy
  a_r7_busy_no_load: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE) |-> !ld);
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   mplier,
  input  logic [N-1:0]   mcand,
  output logic [2*N-1:0] product,
  output logic           done
);
  logic         ld, ad, sh, k, mbit;
  logic [2*N:0] acc;

  shiftadd_mult_datapath #(.N(N)) u_dp (
    .clk(clk), .rst(rst), .ld(ld), .ad(ad), .sh(sh),
    .mplier(mplier), .mcand(mcand), .acc(acc), .mbit(mbit)
  );

  shiftadd_mult_counter #(.N(N)) u_cnt (
    .clk(clk), .rst(rst), .ld(ld), .sh(sh), .k(k)
  );

  shiftadd_mult_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .mbit(mbit), .k(k),
    .ld(ld), .ad(ad), .sh(sh), .done(done)
  );

  assign product = acc[2*N-1:0];

  // R8: the top accumulator bit is clear when the result is presented
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    done |-> acc[2*N] == 1'b0);
endmodule

// File: tb/shiftadd_mult_tb.sv
module shiftadd_mult_tb;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   mplier = '0;
  logic [N-1:0]   mcand = '0;
  logic [2*N-1:0] product;
  logic           done;

  int tests = 0;
  int fails = 0;

  // behavioural reference state
  bit m_idle = 1'b1;
  int m_rem = 0;
  int m_prod = 0;
  bit m_done = 1'b0;
  bit m_loaded = 1'b0;
  int m_low = 0;
  bit check_on = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shiftadd_mult #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mplier(mplier),
    .mcand(mcand), .product(product), .done(done)
  );

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += v[i];
    return c;
  endfunction

  always @(posedge clk) begin
    m_loaded = 1'b0;
    if (rst) begin
      m_idle = 1'b1; m_done = 1'b0; m_rem = 0;
    end else begin
      m_done = 1'b0;
      if (!m_idle) begin
        m_rem--;
        if (m_rem == 0) begin m_done = 1'b1; m_idle = 1'b1; end
      end else if (start) begin
        // R2, R9: start accepted when idle, including the done cycle
        m_idle = 1'b0;
        m_rem = N + ones(mplier);
        m_prod = int'(mplier) * int'(mcand);
        m_low = int'(mplier);
        m_loaded = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (check_on) begin
      tests++;
      if (done !== m_done) begin
        fails++;
        $display("FAIL R5/R6 done timing: got %0b expected %0b at %0t", done, m_done, $time);
      end
      if (m_done) begin
        tests++;
        if (int'(product) != m_prod) begin
          fails++;
          $display("FAIL R3/R4/R6 product: got %0d expected %0d", product, m_prod);
        end
      end
      if (m_loaded) begin
        tests++;
        if (int'(product) != m_low) begin
          fails++;
          $display("FAIL R2 load: got %0d expected %0d", product, m_low);
        end
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!m_idle) @(negedge clk);
  endtask

  task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    mplier = a; mcand = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  initial begin : watchdog
    #1500000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    tests++;
    if (done !== 1'b0 || product !== '0) begin
      fails++;
      $display("FAIL R1 reset: got done=%0b product=%0d expected 0 0", done, product);
    end
    rst = 1'b0;
    check_on = 1'b1;

    // R8 corner, then distinct patterns
    run_mul(4'hF, 4'hF);
    run_mul(4'h0, 4'h0);
    run_mul(4'h8, 4'h8);
    // exhaustive sweep: R3, R4, R5, R6
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_mul(4'(a), 4'(b));

    // R7: start pulses in mid-operation are ignored
    @(negedge clk);
    mplier = 4'hB; mcand = 4'h9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mplier = 4'h3; mcand = 4'h2; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mplier = 4'h1; mcand = 4'h1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R9: start held high gives back-to-back operations
    @(negedge clk);
    mplier = 4'h7; mcand = 4'hD; start = 1'b1;
    repeat (40) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule